// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Pipeline Sequencer

This block is the timing and control core of a small single-issue processor. It runs from the oscillator clock and splits every four oscillator periods into one instruction cycle made of four non-overlapping phases. It uses those phases to run a two-stage pipeline: while one instruction executes, the next one is fetched. It holds the program counter (the fetch address) and the instruction register, and it produces phase-aligned strobes for the data-memory operand read and result write.

A taken branch is reported by the execute logic during the execute cycle. The instruction that was prefetched behind the branch is discarded and replaced by a forced no-operation. The program counter is then loaded with the branch target, so a branch occupies two instruction cycles. Decode, the ALU and the memories sit outside the block. The instruction word arrives combinationally from program memory, addressed by the program counter. The branch inputs are plain level signals. There is no handshake on any port, because the phase timing sets when each value is taken.

Top module: `qphase_seq`

## Requirements
- R1: Exactly one bit of `q_strobe` is high in every oscillator cycle. Bit 0 is phase 1 and bit 3 is phase 4. The active bit advances 1→2→3→4→1 on each clock.
- R2: `cyc_clk` is high during phases 1 and 2 and low during phases 3 and 4.
- R3: `pc` changes only on the clock edge that ends phase 1. In the first instruction cycle after reset it holds 0. Each later cycle without a pending branch fetches the previous address plus one.
- R4: `instr_in` is captured into `ir` on the edge that ends phase 4. It is presented from the next phase 1 for the whole following cycle, and `exec_valid` is 1 for that cycle.
- R5: `mem_rd` is high exactly during phase 2 of a cycle with `exec_valid` = 1, and low at all other times.
- R6: `mem_wr` is high exactly during phase 4 of a cycle with `exec_valid` = 1, and low at all other times.
- R7: Synchronous reset puts the sequencer in phase 1 and sets `pc` to 0. It sets `ir` to the no-operation word (parameter `NOP_WORD`, default 0) and `exec_valid` to 0. No memory strobe fires in the first instruction cycle after reset.
- R8: If `branch_taken` is 1 at the edge ending phase 4 of a valid cycle, the next cycle has `ir` = `NOP_WORD` and `exec_valid` = 0. No memory strobe fires in that cycle, and `pc` equals the `branch_target` sampled at that edge from phase 2 onward. The cycle after that executes the word fetched from the target, and `pc` = target + 1.
- R9: `branch_taken` and `branch_target` are ignored when `exec_valid` is 0, that is, in a flushed slot or in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_in | input | IW | Instruction word read from program memory at `pc` |
| branch_taken | input | 1 | Execute logic reports a taken branch |
| branch_target | input | PC_W | Address the branch jumps to |
| pc | output | PC_W | Program counter (current fetch address) |
| ir | output | IW | Instruction register (instruction in execute) |
| q_strobe | output | 4 | One-hot phase strobes, bit 0 = phase 1 |
| cyc_clk | output | 1 | Instruction-cycle clock, oscillator / 4 |
| exec_valid | output | 1 | Execute slot holds a real instruction |
| mem_rd | output | 1 | Data-memory operand read strobe |
| mem_wr | output | 1 | Data-memory result write strobe |

## Verification
The assertions check on every cycle the following properties: the phase strobes are one-hot and rotate in order, the memory strobes appear only in their own phase, `pc` and `ir` change only at their fixed phase edges, and a branch at phase 4 of a valid cycle always produces an invalid slot after it. Other behaviour can only be shown by the directed scenarios: the actual fetch-address sequence after reset, that the captured word belongs to the address fetched in the previous cycle, that `pc` lands on the target and then the target plus one, and that a second branch request during the flushed slot is ignored.

// File: rtl/qphase_pkg.sv
package qphase_pkg;
  // Phase of the instruction cycle; encoding doubles as the one-hot strobe index
  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  localparam int unsigned NUM_PHASES = 4;
endpackage

// File: rtl/qphase_gen.sv
module qphase_gen
  import qphase_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  output phase_e                ph,
  output logic [NUM_PHASES-1:0] strobe,
  output logic                  cyc_clk
);
  always_ff @(posedge clk) begin
    if (rst) ph <= PH_Q1;
    else     ph <= phase_e'(ph + 2'd1);
  end

  for (genvar i = 0; i < NUM_PHASES; i++) begin : g_strobe
    assign strobe[i] = (ph == phase_e'(i));
  end

  // High for the first half of the instruction cycle
  assign cyc_clk = ~ph[1];

  assert_one_phase_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(strobe) == 1);
  assert_q1_to_q2_R1: assert property (@(posedge clk) disable iff (rst)
    strobe[0] |=> strobe[1]);
  assert_q4_to_q1_R1: assert property (@(posedge clk) disable iff (rst)
    strobe[3] |=> strobe[0]);
  assert_cycclk_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cyc_clk) |-> strobe[0]);
endmodule

// File: rtl/qphase_pc.sv
module qphase_pc #(
  parameter int unsigned PC_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            end_q1,
  input  logic            end_q4,
  input  logic            br_take,
  input  logic [PC_W-1:0] br_target,
  output logic [PC_W-1:0] pc
);
  logic            boot;
  logic            br_pend;
  logic [PC_W-1:0] br_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      boot    <= 1'b1;
      br_pend <= 1'b0;
      br_hold <= '0;
    end else begin
      if (end_q4 && br_take) begin
        br_pend <= 1'b1;
        br_hold <= br_target;
      end
      if (end_q1) begin
        boot <= 1'b0;
        if (br_pend) begin
          pc      <= br_hold;
          br_pend <= 1'b0;
        end else if (!boot) begin
          pc <= pc + 1'b1;
        end
      end
    end
  end

  assert_pc_only_q1_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc) |-> $past(end_q1));
  assert_pc_target_R8: assert property (@(posedge clk) disable iff (rst)
    (end_q1 && br_pend) |=> (pc == $past(br_hold)));
endmodule

// File: rtl/qphase_ir.sv
module qphase_ir #(
  parameter int unsigned       IW       = 16,
  parameter logic [IW-1:0]     NOP_WORD = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          end_q4,
  input  logic          in_q2,
  input  logic          in_q4,
  input  logic [IW-1:0] instr_in,
  input  logic          branch_taken,
  output logic          br_take,
  output logic [IW-1:0] ir,
  output logic          exec_valid,
  output logic          mem_rd,
  output logic          mem_wr
);
  // A branch request counts only while a real instruction executes
  assign br_take = branch_taken && exec_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir         <= NOP_WORD;
      exec_valid <= 1'b0;
    end else if (end_q4) begin
      if (br_take) begin
        ir         <= NOP_WORD;
        exec_valid <= 1'b0;
      end else begin
        ir         <= instr_in;
        exec_valid <= 1'b1;
      end
    end
  end

  assign mem_rd = in_q2 && exec_valid;
  assign mem_wr = in_q4 && exec_valid;

  assert_ir_only_q4_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(ir) |-> $past(end_q4));
  assert_flush_slot_R8: assert property (@(posedge clk) disable iff (rst)
    (end_q4 && exec_valid && branch_taken) |=> (!exec_valid && ir == NOP_WORD));
  assert_no_double_flush_R9: assert property (@(posedge clk) disable iff (rst)
    (end_q4 && !exec_valid) |=> exec_valid);
endmodule

// File: rtl/qphase_seq.sv
module qphase_seq
  import qphase_pkg::*;
#(
  parameter int unsigned   PC_W     = 12,
  parameter int unsigned   IW       = 16,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IW-1:0]   instr_in,
  input  logic            branch_taken,
  input  logic [PC_W-1:0] branch_target,
  output logic [PC_W-1:0] pc,
  output logic [IW-1:0]   ir,
  output logic [3:0]      q_strobe,
  output logic            cyc_clk,
  output logic            exec_valid,
  output logic            mem_rd,
  output logic            mem_wr
);
  phase_e ph;
  logic   br_take;

  qphase_gen u_gen (
    .clk     (clk),
    .rst     (rst),
    .ph      (ph),
    .strobe  (q_strobe),
    .cyc_clk (cyc_clk)
  );

  qphase_pc #(.PC_W(PC_W)) u_pc (
    .clk       (clk),
    .rst       (rst),
    .end_q1    (q_strobe[0]),
    .end_q4    (q_strobe[3]),
    .br_take   (br_take),
    .br_target (branch_target),
    .pc        (pc)
  );

  qphase_ir #(.IW(IW), .NOP_WORD(NOP_WORD)) u_ir (
    .clk          (clk),
    .rst          (rst),
    .end_q4       (q_strobe[3]),
    .in_q2        (q_strobe[1]),
    .in_q4        (q_strobe[3]),
    .instr_in     (instr_in),
    .branch_taken (branch_taken),
    .br_take      (br_take),
    .ir           (ir),
    .exec_valid   (exec_valid),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr)
  );

  assert_rd_in_q2_R5: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (ph == PH_Q2));
  assert_wr_in_q4_R6: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (ph == PH_Q4));
  assert_no_wr_flushed_R8: assert property (@(posedge clk) disable iff (rst)
    !exec_valid |-> !(mem_rd || mem_wr));
endmodule

// File: tb/tb_qphase_seq.sv
module tb_qphase_seq;
  localparam int PC_W = 12;
  localparam int IW   = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [IW-1:0]   instr_in;
  logic            branch_taken = 1'b0;
  logic [PC_W-1:0] branch_target = '0;
  logic [PC_W-1:0] pc;
  logic [IW-1:0]   ir;
  logic [3:0]      q_strobe;
  logic            cyc_clk, exec_valid, mem_rd, mem_wr;

  int checks = 0;
  int errors = 0;
  int exp_ph = 0;

  always #2 clk = ~clk;  // 250 MHz

  function automatic logic [IW-1:0] word_at(logic [PC_W-1:0] a);
    return {4'hA, a};
  endfunction

  assign instr_in = word_at(pc);

  qphase_seq dut (
    .clk(clk), .rst(rst), .instr_in(instr_in), .branch_taken(branch_taken),
    .branch_target(branch_target), .pc(pc), .ir(ir), .q_strobe(q_strobe),
    .cyc_clk(cyc_clk), .exec_valid(exec_valid), .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    exp_ph = (exp_ph + 1) % 4;
    chk("R1 phase strobe", {28'd0, q_strobe}, 32'd1 << exp_ph);
    chk("R2 cycle clock", {31'd0, cyc_clk}, {31'd0, exp_ph < 2});
    chk("R5 read strobe phase", {31'd0, mem_rd && exp_ph != 1}, 0);
    chk("R6 write strobe phase", {31'd0, mem_wr && exp_ph != 3}, 0);
  endtask

  task automatic to_q(int p);
    do step(); while (exp_ph != p);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    exp_ph = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R7 phase Q1", {28'd0, q_strobe}, 32'h1);
    chk("R7 pc", {20'd0, pc}, 0);
    chk("R7 ir nop", {16'd0, ir}, 0);
    chk("R7 valid", {31'd0, exec_valid}, 0);
    to_q(1);
    chk("R3 first fetch 0", {20'd0, pc}, 0);
    chk("R7 no read first cycle", {31'd0, mem_rd}, 0);
    to_q(3);
    chk("R7 no write first cycle", {31'd0, mem_wr}, 0);
  endtask

  task automatic t_stream();
    for (int c = 1; c <= 6; c++) begin
      to_q(0);
      chk("R4 ir word", {16'd0, ir}, {16'd0, word_at(PC_W'(c - 1))});
      chk("R4 valid", {31'd0, exec_valid}, 1);
      to_q(1);
      chk("R3 pc increment", {20'd0, pc}, c);
      chk("R5 read in Q2", {31'd0, mem_rd}, 1);
      to_q(2);
      chk("R5 read off Q3", {31'd0, mem_rd}, 0);
      to_q(3);
      chk("R6 write in Q4", {31'd0, mem_wr}, 1);
    end
  endtask

  task automatic t_branch();
    to_q(0);
    chk("R4 ir before branch", {16'd0, ir}, {16'd0, word_at(12'd6)});
    branch_taken  = 1'b1;
    branch_target = 12'h800;
    to_q(0);
    chk("R8 flushed ir nop", {16'd0, ir}, 0);
    chk("R8 flushed valid", {31'd0, exec_valid}, 0);
    branch_target = 12'h123;  // must be ignored, slot is flushed
    to_q(1);
    chk("R8 pc at target", {20'd0, pc}, 32'h800);
    chk("R8 no read flushed", {31'd0, mem_rd}, 0);
    to_q(3);
    chk("R8 no write flushed", {31'd0, mem_wr}, 0);
    to_q(0);
    branch_taken = 1'b0;
    chk("R8 target word executes", {16'd0, ir}, {16'd0, word_at(12'h800)});
    chk("R9 no second flush", {31'd0, exec_valid}, 1);
    to_q(1);
    chk("R9 pc target+1", {20'd0, pc}, 32'h801);
  endtask

  task automatic t_reset_mid();
    to_q(2);
    do_reset();
    chk("R7 mid reset phase", {28'd0, q_strobe}, 32'h1);
    chk("R7 mid reset pc", {20'd0, pc}, 0);
    chk("R7 mid reset valid", {31'd0, exec_valid}, 0);
    branch_taken  = 1'b1;  // invalid slot: ignored
    branch_target = 12'h456;
    to_q(3);
    branch_taken = 1'b0;
    to_q(0);
    chk("R9 ignored after reset ir", {16'd0, ir}, {16'd0, word_at(12'd0)});
    chk("R9 ignored after reset valid", {31'd0, exec_valid}, 1);
    to_q(1);
    chk("R9 ignored after reset pc", {20'd0, pc}, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_stream();
    t_branch();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule